// File: doc/BRIEF.md
# Three-Wire Serial Converter Read Controller

This block is the host-side master for a 12-bit sampling converter that has an active-low chip select, a data clock driven by the host, and a single serial data line driven by the converter. A read starts on a one-cycle start pulse or on a free-running sample-rate tick. The block then lowers chip select and runs the data clock from the system clock through a divider that can be set at run time. It discards the rising edges that fall in the converter's sampling window and on its leading null bit, and shifts in the result most significant bit first. It can also take in the least-significant-first repeat that the converter sends after the word, and compare it with the word.

Chip select goes high again on the same system clock as the data clock's last falling edge, so the converter is powered for as short a time as possible. The result, a one-cycle valid strobe and a mismatch flag are updated together. After each read the block holds chip select high for at least one full data-clock period before it accepts another request.

Top module: `adc3w_reader`

## Requirements
- R1: After reset cs_no is 1, sclk_o is 0, valid_o is 0, err_o is 0 and result_o is 0.
- R2: A start accepted in idle lowers cs_no. The first rising edge of sclk_o comes exactly H system clocks after that fall, where H = div_i + 1.
- R3: While a read is in progress, each high phase and each low phase of sclk_o lasts exactly H system clocks. While cs_no is 1, sclk_o is 0.
- R4: Rising edges 1 to 3 of sclk_o are not captured (two sampling clocks and the null bit). On rising edges 4 to 15, sdo_i is shifted in most significant bit first, and the resulting 12-bit word appears on result_o.
- R5: A read has 15 rising edges of sclk_o when echo_en_i is 0 at start, and 26 when it is 1. cs_no rises on the same system clock as the falling edge that follows the last rising edge.
- R6: valid_o is high for exactly one system clock, on the clock where cs_no rises. result_o and err_o change only on that clock.
- R7: With the echo check enabled, rising edges 16 to 26 sample echo bits 1 to 11 in that order. err_o is set if any echo bit differs from the same bit of the word. With the check disabled, err_o is 0.
- R8: A start request or a rate tick that arrives while cs_no is low, or during the closing high time, is ignored and does not start a further read.
- R9: cs_no stays high for at least 2H system clocks between two reads.
- R10: While auto_en_i is 1, a read starts every period_i system clocks, so consecutive falls of cs_no are period_i clocks apart when period_i is longer than a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle read request |
| auto_en_i | input | 1 | Enables periodic reads at the sample rate |
| period_i | input | PER_W | Sample period in system clocks |
| div_i | input | DIV_W | Data-clock half period minus one, in system clocks |
| echo_en_i | input | 1 | Enables capture and comparison of the LSB-first repeat |
| sdo_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Data clock to the converter |
| result_o | output | RES_W | Last converted word |
| valid_o | output | 1 | One-cycle strobe when result_o and err_o update |
| err_o | output | 1 | Echo disagreed with the word on the last read |

## Verification
The hardest cases to reach are a request that lands in the short closing high time after chip select rises, and a corrupt echo bit. The bench pulses start one clock after the valid strobe, which puts it inside that window, and also pulses start in the middle of a read. Its converter model can invert one chosen bit of the repeat, with the check enabled and with it disabled. Periodic mode is run with a sample period well above the read length, so the spacing between chip-select falls can be measured exactly.

// File: rtl/adc3w_pkg.sv
package adc3w_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} seq_state_e;
  // two sampling clocks plus the null bit precede the word
  localparam int unsigned LEAD_RISES = 3;
endpackage

// File: rtl/adc3w_rate.sv
module adc3w_rate #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  logic [PER_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == period_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r10_no_tick_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);
endmodule

// File: rtl/adc3w_clkdiv.sv
module adc3w_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && half_i != '0 && $stable(half_i)) |=> !tick_o);
endmodule

// File: rtl/adc3w_capture.sv
module adc3w_capture
  import adc3w_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] rise_idx_i,
  input  logic             sdo_i,
  output logic [RES_W-1:0] word_o,
  output logic             mis_o
);
  localparam int unsigned IDX_W = $clog2(RES_W);
  localparam logic [CNT_W-1:0] DATA_LO = CNT_W'(LEAD_RISES + 1);
  localparam logic [CNT_W-1:0] DATA_HI = CNT_W'(LEAD_RISES + RES_W);
  localparam logic [CNT_W-1:0] ECHO_HI = CNT_W'(LEAD_RISES + 2 * RES_W - 1);

  logic [RES_W-1:0] word_q;
  logic             mis_q;
  logic             in_data, in_echo;
  logic [CNT_W-1:0] echo_pos;
  logic [IDX_W-1:0] bit_sel;

  assign in_data  = (rise_idx_i >= DATA_LO) && (rise_idx_i <= DATA_HI);
  assign in_echo  = (rise_idx_i > DATA_HI) && (rise_idx_i <= ECHO_HI);
  assign echo_pos = rise_idx_i - DATA_HI;
  assign bit_sel  = echo_pos[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      mis_q  <= 1'b0;
    end else if (clear_i) begin
      word_q <= '0;
      mis_q  <= 1'b0;
    end else if (rise_i) begin
      if (in_data) word_q <= {word_q[RES_W-2:0], sdo_i};
      if (in_echo && (sdo_i != word_q[bit_sel])) mis_q <= 1'b1;
    end
  end

  assign word_o = word_q;
  assign mis_o  = mis_q;

  a_r7_mis_from_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mis_q) |-> ($past(rise_i) && $past(rise_idx_i) > DATA_HI));
  a_r4_word_only_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rise_i) && !$past(clear_i) && $past(rise_idx_i) > DATA_HI) |-> $stable(word_q));
endmodule

// File: rtl/adc3w_seq.sv
module adc3w_seq
  import adc3w_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             echo_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tick_i,
  input  logic [RES_W-1:0] word_i,
  input  logic             mis_i,
  output logic             run_o,
  output logic [DIV_W-1:0] half_o,
  output logic             rise_o,
  output logic [CNT_W-1:0] rise_idx_o,
  output logic             clear_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] TOT_PLAIN = CNT_W'(LEAD_RISES + RES_W);
  localparam logic [CNT_W-1:0] TOT_ECHO  = CNT_W'(LEAD_RISES + 2 * RES_W - 1);

  seq_state_e       state_q;
  logic             sclk_q, cs_q, echo_q, gap_q, valid_q, err_q;
  logic [CNT_W-1:0] rise_cnt_q;
  logic [DIV_W-1:0] half_q;
  logic [RES_W-1:0] result_q;
  logic [CNT_W-1:0] total;

  assign total      = echo_q ? TOT_ECHO : TOT_PLAIN;
  assign run_o      = (state_q != ST_IDLE);
  assign half_o     = half_q;
  assign rise_o     = (state_q == ST_RUN) && tick_i && !sclk_q;
  assign rise_idx_o = rise_cnt_q + 1'b1;
  assign clear_o    = (state_q == ST_IDLE) && go_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      echo_q     <= 1'b0;
      gap_q      <= 1'b0;
      valid_q    <= 1'b0;
      err_q      <= 1'b0;
      rise_cnt_q <= '0;
      half_q     <= '0;
      result_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go_i) begin
          state_q    <= ST_RUN;
          cs_q       <= 1'b0;
          sclk_q     <= 1'b0;
          rise_cnt_q <= '0;
          echo_q     <= echo_en_i;
          half_q     <= div_i;
        end
        ST_RUN: if (tick_i) begin
          if (!sclk_q) begin
            sclk_q     <= 1'b1;
            rise_cnt_q <= rise_cnt_q + 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (rise_cnt_q == total) begin
              // release the converter on the final falling edge
              cs_q     <= 1'b1;
              state_q  <= ST_GAP;
              gap_q    <= 1'b0;
              valid_q  <= 1'b1;
              result_q <= word_i;
              err_q    <= mis_i & echo_q;
            end
          end
        end
        ST_GAP: if (tick_i) begin
          if (gap_q) state_q <= ST_IDLE;
          else       gap_q   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no    = cs_q;
  assign sclk_o   = sclk_q;
  assign valid_o  = valid_q;
  assign result_o = result_q;
  assign err_o    = err_q;

  a_r6_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r6_valid_at_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(cs_no));
  a_r3_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  a_r5_rise_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> (rise_cnt_q != '0 && rise_cnt_q <= total));
  a_r6_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(result_o) && $stable(err_o)));
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> ($past(state_q) == ST_IDLE));
endmodule

// File: rtl/adc3w_reader.sv
module adc3w_reader
  import adc3w_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             auto_en_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             echo_en_i,
  input  logic             sdo_i,
  output logic             cs_no,
  output logic             sclk_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic             err_o
);
  localparam int unsigned CNT_W = $clog2(LEAD_RISES + 2 * RES_W) + 1;

  logic             rate_tick, div_tick, run, rise, clear, mis, go;
  logic [DIV_W-1:0] half;
  logic [CNT_W-1:0] rise_idx;
  logic [RES_W-1:0] word;

  assign go = start_i | rate_tick;

  adc3w_rate #(.PER_W(PER_W)) i_rate (
    .clk_i, .rst_ni, .en_i(auto_en_i), .period_i, .tick_o(rate_tick)
  );

  adc3w_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk_i, .rst_ni, .run_i(run), .half_i(half), .tick_o(div_tick)
  );

  adc3w_capture #(.RES_W(RES_W), .CNT_W(CNT_W)) i_capture (
    .clk_i, .rst_ni, .clear_i(clear), .rise_i(rise), .rise_idx_i(rise_idx),
    .sdo_i, .word_o(word), .mis_o(mis)
  );

  adc3w_seq #(.RES_W(RES_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) i_seq (
    .clk_i, .rst_ni, .go_i(go), .echo_en_i, .div_i, .tick_i(div_tick),
    .word_i(word), .mis_i(mis), .run_o(run), .half_o(half), .rise_o(rise),
    .rise_idx_o(rise_idx), .clear_o(clear), .cs_no, .sclk_o, .valid_o,
    .result_o, .err_o
  );
endmodule

// File: tb/test_adc3w_reader.sv
module test_adc3w_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        auto_en = 1'b0;
  logic [15:0] period = 16'd0;
  logic [7:0]  div = 8'd1;
  logic        echo_en = 1'b0;
  logic        sdo = 1'b0;
  logic        cs_no, sclk_o, valid_o, err_o;
  logic [11:0] result_o;

  always #2 clk = ~clk;

  adc3w_reader i_adc3w_reader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .auto_en_i(auto_en),
    .period_i(period), .div_i(div), .echo_en_i(echo_en), .sdo_i(sdo),
    .cs_no(cs_no), .sclk_o(sclk_o), .result_o(result_o), .valid_o(valid_o),
    .err_o(err_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: bits change on falling data-clock edges
  logic [11:0] m_word = 12'h000;
  int          m_bad_f = 0;
  bit          in_xfer = 0;
  int          fcnt = 0;
  always @(negedge cs_no or posedge cs_no or negedge sclk_o) begin
    if (cs_no) begin
      in_xfer = 0;
      sdo <= 1'b0;
    end else if (!in_xfer) begin
      in_xfer = 1;
      fcnt = 0;
    end else begin
      fcnt = fcnt + 1;
      if (fcnt >= 3 && fcnt <= 14)       sdo <= m_word[14-fcnt];
      else if (fcnt >= 15 && fcnt <= 25) sdo <= m_word[fcnt-14] ^ (fcnt == m_bad_f);
      else                               sdo <= 1'b0;
    end
  end

  // scoreboard entries: {echo, err, word}
  logic [13:0] exp_q[$];
  int  cur_h = 2;
  bit  auto_chk = 0;
  int  auto_per = 0;

  int cyc = 0, last_edge = 0, last_csrise = 0, prev_fall = 0, rises = 0, gap_h = 2;
  bit have_rise = 0, have_fall = 0, cs_p = 1, sclk_p = 0, valid_p = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (!auto_chk) have_fall = 0;
      if (cs_p && !cs_no) begin
        if (have_rise) chk(cyc - last_csrise >= 2*gap_h, "R9 cs high gap", cyc - last_csrise, 2*gap_h);
        if (auto_chk && have_fall) chk(cyc - prev_fall == auto_per, "R10 auto spacing", cyc - prev_fall, auto_per);
        prev_fall = cyc; have_fall = 1; rises = 0; last_edge = cyc;
      end
      if (!sclk_p && sclk_o) begin
        rises++;
        if (rises == 1) chk(cyc - last_edge == cur_h, "R2 first rise delay", cyc - last_edge, cur_h);
        else            chk(cyc - last_edge == cur_h, "R3 low phase", cyc - last_edge, cur_h);
        last_edge = cyc;
      end
      if (sclk_p && !sclk_o) begin
        chk(cyc - last_edge == cur_h, "R3 high phase", cyc - last_edge, cur_h);
        last_edge = cyc;
      end
      if (cs_no && sclk_o) chk(0, "R3 sclk high with cs high", 1, 0);
      if (!cs_p && cs_no) begin
        chk(valid_o, "R6 valid on cs rise", valid_o, 1);
        last_csrise = cyc; have_rise = 1; gap_h = cur_h;
      end
      if (valid_o) begin
        chk(!valid_p, "R6 one-cycle strobe", valid_p, 0);
        chk(cs_no && !sclk_o, "R5 cs high with final fall", {cs_no, sclk_o}, 2);
        if (exp_q.size() == 0) chk(0, "R8 unexpected result", result_o, 0);
        else begin
          logic [13:0] e;
          e = exp_q.pop_front();
          chk(result_o == e[11:0], "R4 result word", result_o, e[11:0]);
          chk(err_o == e[12], "R7 echo flag", err_o, e[12]);
          chk(rises == (e[13] ? 26 : 15), "R5 rising edge count", rises, e[13] ? 26 : 15);
        end
      end
      cs_p = cs_no; sclk_p = sclk_o; valid_p = valid_o;
    end
  end

  task automatic wait_valid();
    do @(posedge clk); while (!valid_o);
  endtask

  task automatic read(input logic [11:0] w, input bit echo, input int bad_f, input int h);
    @(negedge clk);
    m_word = w; m_bad_f = bad_f; echo_en = echo;
    div = 8'(h - 1); cur_h = h;
    exp_q.push_back({echo, echo && bad_f != 0, w});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_valid();
    repeat (2*h + 2) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_no == 1'b1, "R1 cs after reset", cs_no, 1);
    chk(sclk_o == 1'b0, "R1 sclk after reset", sclk_o, 0);
    chk(valid_o == 1'b0 && err_o == 1'b0, "R1 strobes after reset", {valid_o, err_o}, 0);
    chk(result_o == 12'h000, "R1 result after reset", result_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    read(12'hA5C, 0, 0, 2);
    read(12'h000, 1, 0, 2);
    read(12'hFFF, 1, 0, 2);
    read(12'h801, 1, 20, 2);   // R7 bit 6 of echo flipped
    read(12'h3C6, 0, 18, 2);   // R7 corruption ignored when check off
    read(12'h5A3, 1, 0, 4);
    read(12'h001, 1, 25, 4);   // R7 echo MSB flipped
    read(12'h9E1, 0, 0, 1);

    // R8: requests during a read and during the closing gap
    @(negedge clk);
    m_word = 12'h7E1; m_bad_f = 0; echo_en = 1; div = 8'd1; cur_h = 2;
    exp_q.push_back({1'b1, 1'b0, 12'h7E1});
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_valid();
    @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    chk(cs_no == 1'b1, "R8 request in gap ignored", cs_no, 1);
    repeat (20) @(negedge clk);
    chk(cs_no == 1'b1 && exp_q.size() == 0, "R8 no extra read", exp_q.size(), 0);

    // R10 periodic reads
    m_word = 12'h9B4; m_bad_f = 0; echo_en = 1; div = 8'd1; cur_h = 2;
    period = 16'd300; auto_per = 300;
    for (int i = 0; i < 3; i++) exp_q.push_back({1'b1, 1'b0, 12'h9B4});
    auto_chk = 1;
    auto_en = 1'b1;
    for (int i = 0; i < 3; i++) wait_valid();
    @(negedge clk);
    auto_en = 1'b0;
    auto_chk = 0;
    repeat (400) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all periodic reads seen", exp_q.size(), 0);
    chk(cs_no == 1'b1, "R10 stops when disabled", cs_no, 1);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule